// File: doc/BRIEF.md
# Token-Steered N-Way Channel Selector

This block joins N valid/ready input channels into one output channel. Which input reaches the output is set by a separate select channel. That channel carries an index as its payload and follows the same valid/ready rules as the data inputs. The output offers a token only while the select token and the input it names are both present. When the output transfers, the select token and the named input's token are both consumed in that same cycle. No other input is acknowledged.

The block has no state. The index is cut to as many low bits as it takes to address N inputs. It is widened back to N bits and used to shift a single set bit, and the resulting one-hot vector steers the ready signals. Inputs may carry a data word, and a parameter decides whether that word passes through a multiplexer or the channels are pure tokens. Producers may raise the select token and the data tokens in any order. The output waits until both are there.

Top module: `chan_select`

## Requirements
- R1: The index used is the low IDX_W bits of `sel_index`, where IDX_W = ceil(log2 N_IN). All higher bits have no effect. With N_IN=4, a payload of 6 (binary 000110) selects input 2.
- R2: `out_valid` is high exactly when `sel_valid` is high and `in_valid[k]` is high, with k the index from R1.
- R3: When PASS_DATA=1, `out_data` equals bits [k*DATA_W +: DATA_W] of `in_data`. When PASS_DATA=0, `out_data` is all zeros.
- R4: `sel_ready` equals `out_valid` AND `out_ready`.
- R5: `in_ready[k]` equals `out_valid` AND `out_ready`. Every other bit of `in_ready` is low at all times, so an input that is not selected is never consumed.
- R6: While `out_ready` is low, `sel_ready` and every bit of `in_ready` are low, whatever the valids are.
- R7: The outputs depend only on the current inputs. A select token that arrives before its data token, or after it, gives `out_valid` in the first cycle in which both are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_valid | input | 1 | Select token present |
| sel_ready | output | 1 | Select token consumed this cycle |
| sel_index | input | SEL_W | Select payload, index in the low bits |
| in_valid | input | N_IN | Per-input token present |
| in_ready | output | N_IN | Per-input consume, one-hot or zero |
| in_data | input | N_IN*DATA_W | Input words, input i in bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | DATA_W | Word of the selected input |

## Verification
The block has no register on any path, so every output is due in the same cycle as the input pattern that produces it. The bench changes all inputs on the falling clock edge and records the expected values at that moment. It samples the outputs on the next rising edge, half a period later, when the combinational paths have settled. Stimuli place the select token before, after and together with the data token. They also include payloads with high bits set and valid inputs that are not selected.

// File: rtl/chsel_pkg.sv
// Package: shared helpers for the channel selector.
// Assumes: callers pass an input count of at least 2.
package chsel_pkg;

    // Number of index bits needed to address n inputs (minimum 1).
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/chsel_decode.sv
// Module: chsel_decode
// Cuts the select payload down to its index bits and turns that index into a
// one-hot vector by shifting a single set bit.
// Assumes: SEL_W >= IDX_W.
module chsel_decode #(
    parameter int N_IN  = 4,
    parameter int SEL_W = 6,
    parameter int IDX_W = 2
) (
    input  logic [SEL_W-1:0] sel_index,
    output logic [IDX_W-1:0] idx,
    output logic [N_IN-1:0]  onehot
);
    logic [N_IN-1:0] idx_wide;

    // Drop the payload's upper bits and widen the index to N_IN bits.
    always_comb begin
        idx      = sel_index[IDX_W-1:0];
        idx_wide = N_IN'(idx);
    end

    // Shift a single set bit into the indexed position.
    always_comb begin
        onehot = N_IN'(1) << idx_wide;
    end

endmodule

// File: rtl/chsel_vpick.sv
// Module: chsel_vpick
// Picks the valid bit of the indexed input and qualifies it with the select
// token's valid.
// Assumes: an index with no matching input reads as not valid.
module chsel_vpick #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  in_valid,
    input  logic [IDX_W-1:0] idx,
    input  logic             sel_valid,
    output logic             out_valid
);
    logic picked;

    // Scan the inputs for the one whose position matches the index.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (idx == IDX_W'(i)) picked = in_valid[i];
        end
    end

    // The output is valid only while the select token is also present.
    always_comb begin
        out_valid = picked & sel_valid;
    end

endmodule

// File: rtl/chsel_rdy.sv
// Module: chsel_rdy
// Turns an output transfer into consume strobes for the select channel and
// for the one input chosen by the one-hot vector.
// Assumes: onehot has at most one bit set.
module chsel_rdy #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0] onehot,
    input  logic            out_valid,
    input  logic            out_ready,
    output logic            sel_ready,
    output logic [N_IN-1:0] in_ready
);
    logic fire;

    // A transfer happens when the output is offered and accepted.
    always_comb begin
        fire      = out_valid & out_ready;
        sel_ready = fire;
        in_ready  = onehot & {N_IN{fire}};
    end

    // R5
    always_comb begin
        inrdy_onehot_chk: assert ($onehot0(in_ready))
            else $error("more than one input consumed");
    end

    // R6
    always_comb begin
        inrdy_needs_accept_chk: assert (!(|in_ready) || out_ready)
            else $error("input consumed while output not accepted");
    end

endmodule

// File: rtl/chsel_dpick.sv
// Module: chsel_dpick
// Passes the indexed input's data word to the output.
// Assumes: in_data holds input i in bits [i*DATA_W +: DATA_W].
module chsel_dpick #(
    parameter int N_IN   = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic [N_IN*DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]       idx,
    output logic [DATA_W-1:0]      out_data
);
    // Select the slice whose position matches the index.
    always_comb begin
        out_data = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (idx == IDX_W'(i)) out_data = in_data[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/chan_select.sv
// Module: chan_select
// N-way channel selector steered by a handshaked select token. An output
// transfer consumes the select token and the chosen input together.
// Assumes: N_IN >= 2, SEL_W >= ceil(log2 N_IN), DATA_W >= 1. No clock.
module chan_select #(
    parameter int N_IN      = 4,
    parameter int SEL_W     = 6,
    parameter int DATA_W    = 8,
    parameter bit PASS_DATA = 1'b1
) (
    input  logic                   sel_valid,
    output logic                   sel_ready,
    input  logic [SEL_W-1:0]       sel_index,
    input  logic [N_IN-1:0]        in_valid,
    output logic [N_IN-1:0]        in_ready,
    input  logic [N_IN*DATA_W-1:0] in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DATA_W-1:0]      out_data
);
    localparam int IDX_W = chsel_pkg::idx_bits(N_IN);

    logic [IDX_W-1:0] idx;
    logic [N_IN-1:0]  onehot;

    chsel_decode #(.N_IN(N_IN), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
        .sel_index (sel_index),
        .idx       (idx),
        .onehot    (onehot)
    );

    chsel_vpick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_vpick (
        .in_valid  (in_valid),
        .idx       (idx),
        .sel_valid (sel_valid),
        .out_valid (out_valid)
    );

    chsel_rdy #(.N_IN(N_IN)) u_rdy (
        .onehot    (onehot),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .sel_ready (sel_ready),
        .in_ready  (in_ready)
    );

    generate
        if (PASS_DATA) begin : g_data
            chsel_dpick #(.N_IN(N_IN), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dpick (
                .in_data  (in_data),
                .idx      (idx),
                .out_data (out_data)
            );
        end else begin : g_token
            // Pure tokens: no data path.
            assign out_data = '0;
        end
    endgenerate

    // R2
    always_comb begin
        outv_needs_sel_chk: assert (!out_valid || sel_valid)
            else $error("output valid without select token");
    end

    // R4
    always_comb begin
        selrdy_with_input_chk: assert (sel_ready == (|in_ready))
            else $error("select and input consumed apart");
    end

    // R5
    always_comb begin
        inrdy_matches_valid_chk: assert ((in_ready & ~in_valid) == '0)
            else $error("input consumed without a token");
    end

endmodule

// File: tb/sim_chan_select.sv
module sim_chan_select;
    localparam int N_IN = 4;
    localparam int SEL_W = 6;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                   sel_valid = 1'b0;
    logic                   sel_ready;
    logic [SEL_W-1:0]       sel_index = '0;
    logic [N_IN-1:0]        in_valid = '0;
    logic [N_IN-1:0]        in_ready;
    logic [N_IN*DATA_W-1:0] in_data = '0;
    logic                   out_valid;
    logic                   out_ready = 1'b0;
    logic [DATA_W-1:0]      out_data;

    chan_select #(.N_IN(N_IN), .SEL_W(SEL_W), .DATA_W(DATA_W), .PASS_DATA(1'b1)) u0 (
        .sel_valid (sel_valid),
        .sel_ready (sel_ready),
        .sel_index (sel_index),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    typedef struct {
        string           tag;
        logic            ev;
        logic            esr;
        logic [N_IN-1:0] eir;
        logic [DATA_W-1:0] ed;
        logic            chk_data;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit drv_done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: apply a pattern on the falling edge and queue its expected result.
    task automatic drive(input string tag, input logic sv, input logic [SEL_W-1:0] si,
                         input logic [N_IN-1:0] iv, input logic ordy);
        exp_t e;
        int k;
        @(negedge clk);
        sel_valid = sv;
        sel_index = si;
        in_valid  = iv;
        out_ready = ordy;
        k = int'(si) % N_IN;
        e.tag = tag;
        e.ev  = sv & iv[k];
        e.esr = e.ev & ordy;
        e.eir = e.esr ? (N_IN'(1) << k) : '0;
        e.ed  = in_data[k*DATA_W +: DATA_W];
        e.chk_data = 1'b1;
        q.push_back(e);
    endtask

    // Monitor: compare queued expectations on the rising edge.
    always @(posedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, "/R2 out_valid"}, 32'(out_valid), 32'(e.ev));
            chk({e.tag, "/R4 sel_ready"}, 32'(sel_ready), 32'(e.esr));
            chk({e.tag, "/R5 in_ready"}, 32'(in_ready), 32'(e.eir));
            if (e.chk_data) chk({e.tag, "/R3 out_data"}, 32'(out_data), 32'(e.ed));
        end
    end

    initial begin
        in_data = {8'hD3, 8'hC2, 8'hB1, 8'hA0};
        repeat (3) @(posedge clk);
        #1;
        // Reset state: no tokens anywhere gives no valid and no consume.
        chk("RST/R2 out_valid", 32'(out_valid), 32'd0);
        chk("RST/R5 in_ready", 32'(in_ready), 32'd0);
        rst_n = 1'b1;

        // R7: select token first, data arrives later.
        drive("R7-selfirst", 1'b1, 6'd1, 4'b0000, 1'b1);
        drive("R7-selfirst", 1'b1, 6'd1, 4'b0010, 1'b1);
        // R7: data token first, select arrives later.
        drive("R7-datafirst", 1'b0, 6'd3, 4'b1000, 1'b1);
        drive("R7-datafirst", 1'b1, 6'd3, 4'b1000, 1'b1);
        // R6: both tokens present, output stalled.
        drive("R6", 1'b1, 6'd2, 4'b1111, 1'b0);
        drive("R6", 1'b1, 6'd0, 4'b0001, 1'b0);
        // R5: other inputs valid, selected one absent -> nothing consumed.
        drive("R5-unsel", 1'b1, 6'd0, 4'b1110, 1'b1);
        drive("R5-unsel", 1'b1, 6'd2, 4'b1011, 1'b1);
        // R1: upper payload bits ignored.
        drive("R1", 1'b1, 6'd6, 4'b1111, 1'b1);
        drive("R1", 1'b1, 6'b111101, 4'b0010, 1'b1);
        drive("R1", 1'b1, 6'b100011, 4'b0111, 1'b1);
        // Every index with all inputs valid and new data.
        @(negedge clk);
        in_data = {8'h5C, 8'h3E, 8'h99, 8'h01};
        for (int i = 0; i < N_IN; i++) drive("R3-sweep", 1'b1, SEL_W'(i), 4'b1111, 1'b1);
        drive("R2-nosel", 1'b0, 6'd2, 4'b1111, 1'b1);
        repeat (3) @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (drv_done && q.size() == 0);
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule